// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block is a register-programmed timer with four independent 16-bit counter channels. Each channel drives one output pin. A shared run register starts and stops the channels. Each channel has a control register, a mode register, a pin-control register, a counter and four compare registers. The control register picks three things: which compare register clears the counter, which edges of the external count source advance it, and a prescale ratio. The pin-control register sets the pin's initial level and what the pin does when the counter reaches compare A.

In PWM mode, compare A sets the duty edge and the clearing compare register sets the period. The pin starts each period at its initial level, takes the compare-A action partway through, and returns to the initial level when the counter clears. Software parks the pin at a fixed level by stopping the channel and writing the pin-control register. The pin then keeps that level until the channel runs again.

The bus is a plain 16-bit port. A write is a one-cycle strobe, and read data is a combinational function of the address. Channel `n` has a 64-byte register window that starts at 0x10 + 0x40·n.

Top module: `pwmt_top`

## Requirements
- R1: After reset all run bits are 0, all channel registers and counters read 0 and every pin is low. Reset asserts asynchronously, and internal logic leaves reset on the second clock edge after `rst_n` rises.
- R2: Address 0x00 holds the run bits, with bit n for channel n. Inside channel n's window the offsets are: control at 0x00 (8 bits), mode at 0x04, pin control at 0x08 (3 bits), counter at 0x14, and compare A/B/C/D at 0x18/0x1C/0x20/0x24. Every other address, including window offsets 0x0C and 0x10, reads 0 and ignores writes.
- R3: Control bits 4:3 select the edges of `cnt_src` that are counted: 0 selects rising edges only, 1 selects falling edges only, and 2 or 3 selects both.
- R4: Control bits 2:0 select the prescale: 0 is divide by 1, 1 is divide by 4, 2 is divide by 16, and 3 or more is divide by 64. The counter advances once for each group of that many selected edges. The divider restarts from zero while the channel is stopped.
- R5: Control bits 7:5 select the clear source: 1 is compare A, 2 is compare B, 5 is compare C and 6 is compare D. When a count step occurs while the counter equals the selected compare value, the counter goes to 0 instead of incrementing. Any other code lets the counter wrap from 0xFFFF to 0.
- R6: While a channel's run bit is 0, its counter and pin hold their values. A bus write to the counter loads it at any time, and it takes priority over a count step.
- R7: A write to pin control while the channel is stopped loads the pin with bit 2 of the written value. The same write while the channel is running does not change the pin.
- R8: On a count step where the counter equals compare A, pin-control bits 1:0 act on the pin: 0 leaves it unchanged, 1 drives it low, 2 drives it high and 3 toggles it.
- R9: In PWM mode, a count step that clears the counter returns the pin to pin-control bit 2. This restore overrides a compare-A action on the same step.
- R10: In PWM mode with compare A greater than or equal to the clear value, the pin stays at its initial level through every period.
- R11: A new compare A value written while running is used from the next count step onward.
- R12: Mode bits 3:0 select the operating mode: 2 is PWM and any other value is normal. Bits 15:4 of a mode write are dropped and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_src | input | 1 | External count source level, synchronous to clk |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pwm_out | output | 4 | One output pin per channel |

## Verification
The assertions assume that `cnt_src` is already synchronous to `clk`. They only require a counter or pin to stay put in cycles without a bus write, because a write may legally load a counter, a run bit or a parked pin level. The stimulus changes `cnt_src` only at falling clock edges and issues one-cycle write strobes. A cycle-level reference in the bench tracks every write and edge, so random register traffic, including counter loads during counting, stays inside what the reference predicts. The directed pulse sequences give exact, hand-counted edge totals for the prescale, clear and PWM corner cases.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int OFFS_W   = 6;
  localparam int PSEL_W   = 3;
  localparam int NUM_CMP  = 4;

  localparam logic [OFFS_W-1:0] OFF_CTRL = 6'h00;
  localparam logic [OFFS_W-1:0] OFF_MODE = 6'h04;
  localparam logic [OFFS_W-1:0] OFF_PINC = 6'h08;
  localparam logic [OFFS_W-1:0] OFF_CNT  = 6'h14;
  localparam logic [OFFS_W-1:0] OFF_CMP0 = 6'h18;

  localparam logic [3:0] MODE_PWM = 4'd2;

  typedef enum logic [1:0] {
    PACT_KEEP = 2'd0,
    PACT_LOW  = 2'd1,
    PACT_HIGH = 2'd2,
    PACT_FLIP = 2'd3
  } pin_act_e;

  typedef enum logic [1:0] {
    EDG_RISE  = 2'd0,
    EDG_FALL  = 2'd1,
    EDG_BOTH  = 2'd2,
    EDG_BOTHX = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic       en;
    logic [1:0] idx;
  } clr_src_t;

  function automatic clr_src_t clr_decode(input logic [2:0] code);
    clr_src_t r;
    r = '0;
    case (code)
      3'd1: begin r.en = 1'b1; r.idx = 2'd0; end
      3'd2: begin r.en = 1'b1; r.idx = 2'd1; end
      3'd5: begin r.en = 1'b1; r.idx = 2'd2; end
      3'd6: begin r.en = 1'b1; r.idx = 2'd3; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwmt_tick.sv
module pwmt_tick
  import pwmt_pkg::*;
#(
  parameter int PSC_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_rise,
  input  logic              src_fall,
  input  logic [1:0]        edge_sel,
  input  logic [PSEL_W-1:0] psc_sel,
  output logic              tick
);

  localparam int PSC_W = 2 * (PSC_STEPS - 1);

  logic [PSC_W-1:0]  div_q, div_d;
  logic [PSC_W-1:0]  mask;
  logic [PSEL_W-1:0] sel_c;
  logic              base;

  always_comb begin
    case (edge_sel_e'(edge_sel))
      EDG_RISE: base = src_rise;
      EDG_FALL: base = src_fall;
      default:  base = src_rise | src_fall;
    endcase
  end

  always_comb begin
    sel_c = (psc_sel > PSEL_W'(PSC_STEPS - 1)) ? PSEL_W'(PSC_STEPS - 1) : psc_sel;
    mask  = PSC_W'((1 << (2 * int'(sel_c))) - 1);
  end

  assign tick = run && base && ((div_q & mask) == mask);

  always_comb begin
    if (!run)       div_d = '0;
    else if (base)  div_d = div_q + PSC_W'(1);
    else            div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PSC_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_rise,
  input  logic              src_fall,
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] wr_off,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [OFFS_W-1:0] rd_off,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tick_o,
  output logic              pin_o
);

  logic [7:0]       ctrl_q;
  logic [3:0]       mode_q;
  logic [2:0]       pinc_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pin_q, pin_d;
  logic [CNT_W-1:0] cmp_q [NUM_CMP];

  logic             wr_ctrl, wr_mode, wr_pinc, wr_cnt;
  logic             tick;
  clr_src_t         clr;
  logic             at_clr, at_a, pwm_mode;

  assign wr_ctrl = wr_en && (wr_off == OFF_CTRL);
  assign wr_mode = wr_en && (wr_off == OFF_MODE);
  assign wr_pinc = wr_en && (wr_off == OFF_PINC);
  assign wr_cnt  = wr_en && (wr_off == OFF_CNT);

  pwmt_tick #(.PSC_STEPS(PSC_STEPS)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .src_rise (src_rise),
    .src_fall (src_fall),
    .edge_sel (ctrl_q[4:3]),
    .psc_sel  (ctrl_q[PSEL_W-1:0]),
    .tick     (tick)
  );

  assign clr      = clr_decode(ctrl_q[7:5]);
  assign at_clr   = clr.en && (cnt_q == cmp_q[clr.idx]);
  assign at_a     = (cnt_q == cmp_q[0]);
  assign pwm_mode = (mode_q == MODE_PWM);

  // counter next state: bus load beats count step
  always_comb begin
    if (wr_cnt)      cnt_d = wr_data;
    else if (tick)   cnt_d = at_clr ? '0 : cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  // pin next state: park load, then period restore, then compare-A action
  always_comb begin
    pin_d = pin_q;
    if (!run && wr_pinc) begin
      pin_d = wr_data[2];
    end else if (tick) begin
      if (pwm_mode && at_clr) begin
        pin_d = pinc_q[2];
      end else if (at_a) begin
        case (pin_act_e'(pinc_q[1:0]))
          PACT_LOW:  pin_d = 1'b0;
          PACT_HIGH: pin_d = 1'b1;
          PACT_FLIP: pin_d = ~pin_q;
          default:   pin_d = pin_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= wr_data[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pinc_q <= '0;
    else if (wr_pinc) pinc_q <= wr_data[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pin_q <= pin_d;
    end
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic wr_k;
    assign wr_k = wr_en && (wr_off == OFF_CMP0 + OFFS_W'(4 * k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmp_q[k] <= '0;
      else if (wr_k) cmp_q[k] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_off)
      OFF_CTRL: rd_data[7:0] = ctrl_q;
      OFF_MODE: rd_data[3:0] = mode_q;
      OFF_PINC: rd_data[2:0] = pinc_q;
      OFF_CNT:  rd_data      = cnt_q;
      6'h18:    rd_data      = cmp_q[0];
      6'h1C:    rd_data      = cmp_q[1];
      6'h20:    rd_data      = cmp_q[2];
      6'h24:    rd_data      = cmp_q[3];
      default:  rd_data      = '0;
    endcase
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick;
  assign pin_o  = pin_q;

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int PSC_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_src,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int WIN_BASE = 16;
  localparam int IDX_W    = ADDR_W - OFFS_W;

  logic [1:0]              rst_pipe_q;
  logic                    rst_sync_n;
  logic [NCH-1:0]          run_q, run_d;
  logic                    src_q;
  logic                    src_rise, src_fall;
  logic [ADDR_W-1:0]       rel_addr;
  logic [IDX_W-1:0]        win_idx;
  logic [OFFS_W-1:0]       win_off;
  logic                    in_win;
  logic [CNT_W-1:0]        ch_rd [NCH];
  logic [NCH-1:0][CNT_W-1:0] ch_cnt;
  logic [NCH-1:0]          ch_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign in_win   = (bus_addr >= ADDR_W'(WIN_BASE));
  assign rel_addr = bus_addr - ADDR_W'(WIN_BASE);
  assign win_idx  = rel_addr[ADDR_W-1:OFFS_W];
  assign win_off  = rel_addr[OFFS_W-1:0];

  always_comb begin
    run_d = run_q;
    if (bus_wr && (bus_addr == '0)) run_d = bus_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= '0;
      src_q <= 1'b0;
    end else begin
      run_q <= run_d;
      src_q <= cnt_src;
    end
  end

  assign src_rise = cnt_src & ~src_q;
  assign src_fall = ~cnt_src & src_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = in_win && (int'(win_idx) == i);
    pwmt_channel #(.CNT_W(CNT_W), .PSC_STEPS(PSC_STEPS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .run      (run_q[i]),
      .src_rise (src_rise),
      .src_fall (src_fall),
      .wr_en    (bus_wr && hit),
      .wr_off   (win_off),
      .wr_data  (bus_wdata),
      .rd_off   (win_off),
      .rd_data  (ch_rd[i]),
      .cnt_o    (ch_cnt[i]),
      .tick_o   (ch_tick[i]),
      .pin_o    (pwm_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0)                      bus_rdata[NCH-1:0] = run_q;
    else if (in_win && int'(win_idx) < NCH)  bus_rdata = ch_rd[win_idx];
  end

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [NCH-1:0]            run_q,
  input logic [NCH-1:0]            ch_tick,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0]            pwm_out
);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && !bus_wr) |=> (ch_cnt[i] == $past(ch_cnt[i])) && (pwm_out[i] == $past(pwm_out[i])));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tick[i] && !bus_wr) |=>
        (ch_cnt[i] == CNT_W'($past(ch_cnt[i]) + 1'b1)) || (ch_cnt[i] == '0));

    assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> run_q[i]);

    assert_cnt_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_tick[i] && !bus_wr) |=> $stable(ch_cnt[i]));

    assert_pin_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_tick[i] && !bus_wr) |=> $stable(pwm_out[i]));
  end

endmodule

bind pwmt_top pwmt_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .bus_wr  (bus_wr),
  .run_q   (run_q),
  .ch_tick (ch_tick),
  .ch_cnt  (ch_cnt),
  .pwm_out (pwm_out)
);

// File: tb/sim_pwmt_top.sv
module sim_pwmt_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_src;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  logic mon_on = 1'b0;

  always #4 clk = ~clk;

  pwmt_top #(.NCH(4), .CNT_W(16), .ADDR_W(8), .PSC_STEPS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_src(cnt_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // reference state, built from the requirements
  logic [3:0]  m_run;
  logic [7:0]  m_ctrl [4];
  logic [3:0]  m_mode [4];
  logic [2:0]  m_pinc [4];
  logic [15:0] m_cnt  [4];
  logic [15:0] m_cmp  [4][4];
  logic        m_pin  [4];
  logic [5:0]  m_div  [4];
  logic        m_srcq;

  always @(posedge clk or negedge rst_n) begin : model
    logic rise, fall, base, tk, hitc, hita, pwm, ce, wr_here;
    logic [5:0] mask;
    logic [2:0] s;
    logic [7:0] off;
    int ci;
    if (!rst_n) begin
      m_run = 0; m_srcq = 0;
      for (int c = 0; c < 4; c++) begin
        m_ctrl[c] = 0; m_mode[c] = 0; m_pinc[c] = 0; m_cnt[c] = 0;
        m_pin[c] = 0; m_div[c] = 0;
        for (int k = 0; k < 4; k++) m_cmp[c][k] = 0;
      end
    end else begin
      rise = cnt_src & ~m_srcq;
      fall = ~cnt_src & m_srcq;
      off  = 8'(bus_addr - 8'd16) & 8'h3F;
      for (int c = 0; c < 4; c++) begin
        case (m_ctrl[c][4:3])
          2'd0: base = rise;
          2'd1: base = fall;
          default: base = rise | fall;
        endcase
        s    = (m_ctrl[c][2:0] > 3) ? 3'd3 : m_ctrl[c][2:0];
        mask = 6'((1 << (2 * int'(s))) - 1);
        tk   = m_run[c] && base && ((m_div[c] & mask) == mask);
        m_div[c] = !m_run[c] ? 6'd0 : (base ? 6'(m_div[c] + 1) : m_div[c]);
        ce = 1; ci = 0;
        case (m_ctrl[c][7:5])
          3'd1: ci = 0;
          3'd2: ci = 1;
          3'd5: ci = 2;
          3'd6: ci = 3;
          default: ce = 0;
        endcase
        hitc = ce && (m_cnt[c] == m_cmp[c][ci]);
        hita = (m_cnt[c] == m_cmp[c][0]);
        pwm  = (m_mode[c] == 4'd2);
        wr_here = bus_wr && (bus_addr >= 16) && (int'((bus_addr - 8'd16) >> 6) == c);
        if (!m_run[c] && wr_here && off == 8'h08) m_pin[c] = bus_wdata[2];
        else if (tk) begin
          if (pwm && hitc) m_pin[c] = m_pinc[c][2];
          else if (hita) begin
            case (m_pinc[c][1:0])
              2'd1: m_pin[c] = 1'b0;
              2'd2: m_pin[c] = 1'b1;
              2'd3: m_pin[c] = ~m_pin[c];
              default: ;
            endcase
          end
        end
        if (wr_here && off == 8'h14) m_cnt[c] = bus_wdata;
        else if (tk) m_cnt[c] = hitc ? 16'd0 : 16'(m_cnt[c] + 1);
        if (wr_here) begin
          case (off)
            8'h00: m_ctrl[c] = bus_wdata[7:0];
            8'h04: m_mode[c] = bus_wdata[3:0];
            8'h08: m_pinc[c] = bus_wdata[2:0];
            8'h18: m_cmp[c][0] = bus_wdata;
            8'h1C: m_cmp[c][1] = bus_wdata;
            8'h20: m_cmp[c][2] = bus_wdata;
            8'h24: m_cmp[c][3] = bus_wdata;
            default: ;
          endcase
        end
      end
      if (bus_wr && bus_addr == 8'h00) m_run = bus_wdata[3:0];
      m_srcq = cnt_src;
    end
  end

  function automatic logic [15:0] mread(input logic [7:0] a);
    int c;
    logic [7:0] o;
    if (a == 0) return {12'd0, m_run};
    if (a < 16) return 16'd0;
    c = int'((a - 8'd16) >> 6);
    o = 8'(a - 8'd16) & 8'h3F;
    case (o)
      8'h00: return {8'd0, m_ctrl[c]};
      8'h04: return {12'd0, m_mode[c]};
      8'h08: return {13'd0, m_pinc[c]};
      8'h14: return m_cnt[c];
      8'h18: return m_cmp[c][0];
      8'h1C: return m_cmp[c][1];
      8'h20: return m_cmp[c][2];
      8'h24: return m_cmp[c][3];
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdx(input string tag, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic rdm(input string tag, input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, mread(a));
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      @(negedge clk); cnt_src = 1'b1;
      @(negedge clk); cnt_src = 1'b0;
    end
  endtask

  task automatic pinx(input string tag, input int c, input logic exp);
    @(negedge clk);
    chk(tag, {15'd0, pwm_out[c]}, {15'd0, exp});
  endtask

  // every cycle: pins against the reference (R8, R9)
  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < 4; c++)
        chk("R8/R9 pin vs reference", {15'd0, pwm_out[c]}, {15'd0, m_pin[c]});
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; cnt_src = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 16'h0;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", {12'd0, pwm_out}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    rdx("R1 run bits", 8'h00, 16'h0);
    rdx("R1 counter ch0", 8'h24, 16'h0);
    rdx("R1 compare B ch3", 8'hEC, 16'h0);

    // R2 / R12 map and field widths
    wr(8'h50, 16'hFFFF); rdx("R2 control width", 8'h50, 16'h00FF);
    wr(8'h54, 16'hFFFF); rdx("R12 mode upper bits dropped", 8'h54, 16'h000F);
    wr(8'h58, 16'hFFFF); rdx("R2 pin control width", 8'h58, 16'h0007);
    wr(8'h60, 16'h1234); rdx("R2 offset 0x10 reads zero", 8'h60, 16'h0);
    wr(8'h5C, 16'h4321); rdx("R2 offset 0x0C reads zero", 8'h5C, 16'h0);
    wr(8'h04, 16'hFFFF); rdx("R2 gap address reads zero", 8'h04, 16'h0);
    wr(8'h74, 16'hBEEF); rdx("R2 compare D ch1", 8'h74, 16'hBEEF);
    wr(8'h50, 16'h0); wr(8'h54, 16'h0); wr(8'h58, 16'h0); wr(8'h74, 16'h0);

    // R4 divide by 4 on rising edges
    wr(8'h50, 16'h0001); wr(8'h64, 16'h0); wr(8'h00, 16'h2);
    pulses(8); wr(8'h00, 16'h0);
    rdx("R4 prescale /4 rising", 8'h64, 16'd2);
    // R3 falling only
    wr(8'h50, 16'h0008); wr(8'h64, 16'h0); wr(8'h00, 16'h2);
    pulses(5); wr(8'h00, 16'h0);
    rdx("R3 falling edges", 8'h64, 16'd5);
    // R3 both edges
    wr(8'h50, 16'h0010); wr(8'h64, 16'h0); wr(8'h00, 16'h2);
    pulses(5); wr(8'h00, 16'h0);
    rdx("R3 both edges", 8'h64, 16'd10);

    // R5 clear on compare C
    wr(8'h90, 16'h00A0); wr(8'hB0, 16'd3); wr(8'hA4, 16'h0); wr(8'h00, 16'h4);
    pulses(10); wr(8'h00, 16'h0);
    rdx("R5 clear on compare C", 8'hA4, 16'd2);
    // R5 free running wrap
    wr(8'h90, 16'h0000); wr(8'hA4, 16'hFFFE); wr(8'h00, 16'h4);
    pulses(3); wr(8'h00, 16'h0);
    rdx("R5 wrap past 0xFFFF", 8'hA4, 16'd1);
    // R6 stopped holds, load while stopped
    pulses(5);
    rdx("R6 stopped counter holds", 8'hA4, 16'd1);
    wr(8'hA4, 16'h0123);
    rdx("R6 counter load", 8'hA4, 16'h0123);

    // R7 / R8 normal mode toggle on compare A with clear on A
    wr(8'h10, 16'h0020); wr(8'h28, 16'd3); wr(8'h14, 16'h0);
    wr(8'h18, 16'h0007); pinx("R7 park high", 0, 1'b1);
    wr(8'h18, 16'h0003); pinx("R7 park low", 0, 1'b0);
    wr(8'h24, 16'h0); wr(8'h00, 16'h1);
    pulses(4); pinx("R8 toggle at compare A", 0, 1'b1);
    rdx("R5 clear on compare A", 8'h24, 16'd0);
    pulses(4); pinx("R8 second toggle", 0, 1'b0);
    wr(8'h18, 16'h0007); pinx("R7 running write leaves pin", 0, 1'b0);
    wr(8'h00, 16'h0);

    // R9..R12 PWM on channel 3, clear on B
    wr(8'hD0, 16'h0040); wr(8'hD4, 16'h0072);
    rdx("R12 mode readback", 8'hD4, 16'h0002);
    wr(8'hE8, 16'd2); wr(8'hEC, 16'd5); wr(8'hE4, 16'h0);
    wr(8'hD8, 16'h0005); pinx("R7 park at initial level", 3, 1'b1);
    wr(8'h00, 16'h8);
    pulses(3); pinx("R9 duty edge", 3, 1'b0);
    rdx("R9 counter mid period", 8'hE4, 16'd3);
    pulses(3); pinx("R9 restore at clear", 3, 1'b1);
    rdx("R9 counter cleared", 8'hE4, 16'd0);
    wr(8'hE8, 16'd7);
    for (int j = 0; j < 12; j++) begin
      pulses(1); pinx("R10 compare A above period", 3, 1'b1);
    end
    wr(8'hE8, 16'd1);
    pulses(2); pinx("R11 new compare A used", 3, 1'b0);
    pulses(4); pinx("R9 restore after update", 3, 1'b1);
    wr(8'hE8, 16'd5);
    for (int j = 0; j < 7; j++) begin
      pulses(1); pinx("R10 compare A equal to clear", 3, 1'b1);
    end
    wr(8'h00, 16'h0);

    // random traffic against the reference (R2, R5, R6, R8, R9, R11)
    for (int r = 0; r < 30; r++) begin
      for (int w = 0; w < 6; w++) begin
        logic [7:0] base_a;
        logic [15:0] v;
        base_a = 8'(16 + 64 * ($urandom % 4));
        case ($urandom % 8)
          0: wr(base_a + 8'h00, 16'($urandom % 256) & 16'h00F9);
          1: wr(base_a + 8'h04, 16'($urandom));
          2: wr(base_a + 8'h08, 16'($urandom % 8));
          3: wr(base_a + 8'h14, 16'($urandom % 48));
          4: wr(base_a + 8'h18, 16'($urandom % 48));
          5: wr(base_a + 8'h1C, 16'($urandom % 48));
          6: wr(base_a + 8'h20, 16'($urandom % 48));
          default: begin v = 16'($urandom % 48); wr(base_a + 8'h24, v); end
        endcase
      end
      wr(8'h00, 16'($urandom % 16));
      for (int t = 0; t < 80; t++) begin
        @(negedge clk); cnt_src = 1'($urandom % 2);
      end
      for (int c = 0; c < 4; c++) rdm("R5/R6 random counter", 8'(16 + 64 * c + 'h14));
      rdm("R2 random run bits", 8'h00);
    end

    mon_on = 1'b0;
    summary();
  end

endmodule